// File: doc/BRIEF.md
# Entropy Sampler and Debiasing Conditioner

This block sits between a free-running entropy source and the software-visible random word. It captures the raw source bit on a pacing tick that comes from a programmable divider of the system clock. After a start, a programmable number of captured samples is thrown away so that synchronizer state and oscillator start-up effects never reach the output. Later samples are folded together in groups, and each group becomes one reduced bit.

The reduced bits can pass straight through. They can also go through a von Neumann debiasing stage, which examines them two at a time and emits a bit only when the two differ. Each bit that survives enters a 32-bit shift register at its least significant end. Once 32 new bits have gathered, the finished word is latched and a valid flag is raised. The flag stays up until a read strobe clears it. Single-cycle strobes expose the sampled, reduced and corrected streams so that a health monitor can observe each one. Dropping the enable resets the pipeline and starts a fresh warm-up.

Top module: `rng_harvest`

## Requirements
- R1: With pacing divider value N, a sample is taken at every (N+1)-th clock edge counted from the first edge with enable high, so N=0 samples on every edge. `samp_stb` is high for one cycle after each sampling edge, and `samp_bit` then shows the raw input as it was at that edge.
- R2: With warm-up value D, the first D+1 samples after enable rises are discarded. `init_pulse` is high for exactly one cycle, and that cycle starts one clock edge after the edge that took sample D+1.
- R3: With grouping value M, every consecutive group of M+1 retained samples produces one reduced bit. That bit is the XOR of the samples in the group, and it is flagged by a one-cycle `red_stb` one edge after the last sample of the group is strobed.
- R4: With `unbias_en` low, each reduced bit appears unchanged on `corr_bit` with a `corr_stb` pulse one edge later.
- R5: With `unbias_en` high, reduced bits are taken in non-overlapping pairs, earlier bit first. Pairs 00 and 11 give nothing, pair 01 gives 0 and pair 10 gives 1 (the earlier bit). The output is strobed one edge after the second bit of the pair.
- R6: Each corrected bit enters `result` at bit 0 as the older bits shift up, so the first of 32 bits ends at bit 31. `result_valid` rises and `ready_pulse` fires for one cycle one edge after the 32nd bit's `corr_stb`, which is three edges after the sampling edge of the last sample that contributes to that bit.
- R7: While `result_valid` is high and no new word completes, `result` stays unchanged. A `word_read` strobe clears `result_valid` at the next edge unless a word completes on that same edge.
- R8: With enable low, all strobes are low. The divider, warm-up, group, pair and bit counters clear, so a later enable runs the warm-up again and produces exactly the word a fresh start would.
- R9: After reset, `result` is zero and `result_valid`, `ready_pulse`, `init_pulse` and all stream strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the pipeline; low clears it |
| raw_bit | input | 1 | Entropy source bit, already synchronized |
| samp_div | input | 8 | Pacing divider N (one sample per N+1 clocks) |
| red_div | input | 8 | Grouping value M (one reduced bit per M+1 samples) |
| warm_cnt | input | 8 | Warm-up value D (D+1 samples discarded) |
| unbias_en | input | 1 | Enables the pairwise debiasing stage |
| word_read | input | 1 | Read strobe that clears the valid flag |
| result | output | 32 | Last completed random word |
| result_valid | output | 1 | A completed word is waiting to be read |
| ready_pulse | output | 1 | One-cycle pulse when a word completes |
| init_pulse | output | 1 | One-cycle pulse when warm-up ends |
| samp_stb | output | 1 | Sample stream strobe |
| samp_bit | output | 1 | Sample stream data |
| red_stb | output | 1 | Reduced stream strobe |
| red_bit | output | 1 | Reduced stream data |
| corr_stb | output | 1 | Corrected stream strobe |
| corr_bit | output | 1 | Corrected stream data |

## Verification
Each register stage adds exactly one edge. A sample strobe follows its sampling edge, a reduced or warm-up strobe follows one edge after that, a corrected strobe follows one edge after the reduced strobe, and the valid flag follows one edge after the corrected strobe. The bench therefore expects the word exactly three edges after the sampling edge of the last contributing sample, and the warm-up pulse one edge after sample D+1. It numbers clock edges from the first edge with enable high and changes the raw input in the low phase before each edge. A bench model replays the same numbered input through the requirements and predicts the word, its arrival edge, the warm-up edge and the sample count. All outputs are read at the falling edge after each rising edge, and each one is compared with the value the model gives for that edge number.

// File: rtl/rng_harvest_pkg.sv
package rng_harvest_pkg;

    localparam int DIV_W_DEF  = 8;
    localparam int WORD_W_DEF = 32;

    // one stream element: strobe plus data bit
    typedef struct packed {
        logic stb;
        logic val;
    } tap_t;

    typedef enum logic {
        PAIR_EMPTY = 1'b0,
        PAIR_HALF  = 1'b1
    } pair_st_e;

    // a pair yields output only when its two bits differ
    function automatic logic pair_emits(logic older, logic newer);
        return older ^ newer;
    endfunction

endpackage

// File: rtl/rng_pacer.sv
module rng_pacer
    import rng_harvest_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             raw_bit,
    input  logic [DIV_W-1:0] samp_div,
    output tap_t             samp
);

    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    assign tick = (div_cnt == samp_div);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            div_cnt <= '0;
            samp    <= '0;
        end else begin
            samp.stb <= tick;
            if (tick) begin
                samp.val <= raw_bit;
                div_cnt  <= '0;
            end else begin
                div_cnt  <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rng_reducer.sv
module rng_reducer
    import rng_harvest_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  tap_t             samp,
    input  logic [DIV_W-1:0] red_div,
    input  logic [DIV_W-1:0] warm_cnt,
    output tap_t             red,
    output logic             init_pulse
);

    logic [DIV_W-1:0] drop_cnt;
    logic [DIV_W-1:0] grp_cnt;
    logic             warm_done;
    logic             acc;
    logic             grp_last;
    logic             folded;

    assign grp_last = (grp_cnt == red_div);
    assign folded   = acc ^ samp.val;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            drop_cnt   <= '0;
            grp_cnt    <= '0;
            warm_done  <= 1'b0;
            acc        <= 1'b0;
            red        <= '0;
            init_pulse <= 1'b0;
        end else begin
            red.stb    <= 1'b0;
            init_pulse <= 1'b0;
            if (samp.stb) begin
                if (!warm_done) begin
                    if (drop_cnt == warm_cnt) begin
                        warm_done  <= 1'b1;
                        init_pulse <= 1'b1;
                    end else begin
                        drop_cnt <= drop_cnt + 1'b1;
                    end
                end else if (grp_last) begin
                    red.stb <= 1'b1;
                    red.val <= folded;
                    acc     <= 1'b0;
                    grp_cnt <= '0;
                end else begin
                    acc     <= folded;
                    grp_cnt <= grp_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rng_unbias.sv
module rng_unbias
    import rng_harvest_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic unbias_en,
    input  tap_t red,
    output tap_t corr
);

    pair_st_e pair_st;
    logic     older;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pair_st <= PAIR_EMPTY;
            older   <= 1'b0;
            corr    <= '0;
        end else begin
            corr.stb <= 1'b0;
            if (red.stb) begin
                if (!unbias_en) begin
                    corr.stb <= 1'b1;
                    corr.val <= red.val;
                    pair_st  <= PAIR_EMPTY;
                end else begin
                    case (pair_st)
                        PAIR_EMPTY: begin
                            older   <= red.val;
                            pair_st <= PAIR_HALF;
                        end
                        default: begin
                            pair_st <= PAIR_EMPTY;
                            if (pair_emits(older, red.val)) begin
                                corr.stb <= 1'b1;
                                corr.val <= older;
                            end
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/rng_collect.sv
module rng_collect
    import rng_harvest_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  tap_t              corr,
    input  logic              word_read,
    output logic [WORD_W-1:0] result,
    output logic              result_valid,
    output logic              ready_pulse
);

    localparam int              CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word_next;
    logic [CNT_W-1:0]  bit_cnt;

    assign word_next = {shreg[WORD_W-2:0], corr.val};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg        <= '0;
            bit_cnt      <= '0;
            result       <= '0;
            result_valid <= 1'b0;
            ready_pulse  <= 1'b0;
        end else begin
            ready_pulse <= 1'b0;
            if (word_read) begin
                result_valid <= 1'b0;
            end
            if (!enable) begin
                bit_cnt <= '0;
            end else if (corr.stb) begin
                shreg <= word_next;
                if (bit_cnt == LAST_CNT) begin
                    bit_cnt      <= '0;
                    result       <= word_next;
                    result_valid <= 1'b1;
                    ready_pulse  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rng_harvest.sv
module rng_harvest
    import rng_harvest_pkg::*;
#(
    parameter int DIV_W  = DIV_W_DEF,
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              raw_bit,
    input  logic [DIV_W-1:0]  samp_div,
    input  logic [DIV_W-1:0]  red_div,
    input  logic [DIV_W-1:0]  warm_cnt,
    input  logic              unbias_en,
    input  logic              word_read,
    output logic [WORD_W-1:0] result,
    output logic              result_valid,
    output logic              ready_pulse,
    output logic              init_pulse,
    output logic              samp_stb,
    output logic              samp_bit,
    output logic              red_stb,
    output logic              red_bit,
    output logic              corr_stb,
    output logic              corr_bit
);

    tap_t samp_t;
    tap_t red_t;
    tap_t corr_t;

    rng_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .raw_bit  (raw_bit),
        .samp_div (samp_div),
        .samp     (samp_t)
    );

    rng_reducer #(.DIV_W(DIV_W)) u_reducer (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .samp       (samp_t),
        .red_div    (red_div),
        .warm_cnt   (warm_cnt),
        .red        (red_t),
        .init_pulse (init_pulse)
    );

    rng_unbias u_unbias (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .unbias_en (unbias_en),
        .red       (red_t),
        .corr      (corr_t)
    );

    rng_collect #(.WORD_W(WORD_W)) u_collect (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .corr         (corr_t),
        .word_read    (word_read),
        .result       (result),
        .result_valid (result_valid),
        .ready_pulse  (ready_pulse)
    );

    assign samp_stb = samp_t.stb;
    assign samp_bit = samp_t.val;
    assign red_stb  = red_t.stb;
    assign red_bit  = red_t.val;
    assign corr_stb = corr_t.stb;
    assign corr_bit = corr_t.val;

endmodule

// File: rtl/rng_harvest_chk.sv
module rng_harvest_chk #(
    parameter int DIV_W  = 8,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              raw_bit,
    input logic [DIV_W-1:0]  samp_div,
    input logic [DIV_W-1:0]  red_div,
    input logic [DIV_W-1:0]  warm_cnt,
    input logic              unbias_en,
    input logic              word_read,
    input logic [WORD_W-1:0] result,
    input logic              result_valid,
    input logic              ready_pulse,
    input logic              init_pulse,
    input logic              samp_stb,
    input logic              samp_bit,
    input logic              red_stb,
    input logic              red_bit,
    input logic              corr_stb,
    input logic              corr_bit
);

    // back-to-back samples are only legal with a divider of zero
    p_back_to_back_r1: assert property (@(posedge clk) disable iff (rst)
        (samp_stb && $past(samp_stb)) |-> ($past(samp_div) == '0));

    p_init_follows_sample_r2: assert property (@(posedge clk) disable iff (rst)
        init_pulse |-> $past(samp_stb));

    p_reduced_follows_sample_r3: assert property (@(posedge clk) disable iff (rst)
        red_stb |-> $past(samp_stb));

    p_bypass_passes_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && !unbias_en && red_stb) |=> (corr_stb && (corr_bit == $past(red_bit))));

    p_corrected_follows_reduced_r5: assert property (@(posedge clk) disable iff (rst)
        corr_stb |-> $past(red_stb));

    p_ready_follows_corrected_r6: assert property (@(posedge clk) disable iff (rst)
        ready_pulse |-> ($past(corr_stb) && result_valid));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (word_read && !corr_stb) |=> !result_valid);

    p_word_held_r7: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !ready_pulse) |-> $stable(result));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!samp_stb && !red_stb && !corr_stb && !init_pulse && !ready_pulse));

endmodule

bind rng_harvest rng_harvest_chk #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/rng_harvest_test.sv
`timescale 1ns/1ps
module rng_harvest_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        raw_bit = 1'b0;
    logic [7:0]  samp_div = '0;
    logic [7:0]  red_div = '0;
    logic [7:0]  warm_cnt = '0;
    logic        unbias_en = 1'b0;
    logic        word_read = 1'b0;
    logic [31:0] result;
    logic        result_valid, ready_pulse, init_pulse;
    logic        samp_stb, samp_bit, red_stb, red_bit, corr_stb, corr_bit;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    rng_harvest uut (
        .clk(clk), .rst(rst), .enable(enable), .raw_bit(raw_bit),
        .samp_div(samp_div), .red_div(red_div), .warm_cnt(warm_cnt),
        .unbias_en(unbias_en), .word_read(word_read),
        .result(result), .result_valid(result_valid), .ready_pulse(ready_pulse),
        .init_pulse(init_pulse), .samp_stb(samp_stb), .samp_bit(samp_bit),
        .red_stb(red_stb), .red_bit(red_bit), .corr_stb(corr_stb), .corr_bit(corr_bit)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
        end
    endtask

    // raw input as a function of the edge number
    function automatic bit pat(int sel, int c);
        logic [31:0] h;
        logic [7:0]  seq;
        h   = 32'(c) * 32'h9E3779B1;
        seq = 8'b0110_1100;
        case (sel)
            1:       return (c <= 4) ? 1'b1 : (h[16] ^ h[7]);
            2:       return (c < 2) ? 1'b1 : seq[(c - 2) % 8];
            default: return h[16] ^ h[7];
        endcase
    endfunction

    // requirement model: predicted word and sampling edge of its last sample
    task automatic model(input int n, input int m, input int d, input bit vn, input int sel,
                         output logic [31:0] w, output int last_c);
        int  nb = 0, j = 0, grp = 0, c;
        bit  acc = 0, have = 0, older = 0, b, rb, emit, ebit;
        w = '0;
        last_c = 0;
        while (nb < 32 && j < 100000) begin
            j++;
            c = j * (n + 1);
            b = pat(sel, c);
            if (j <= d + 1) continue;
            acc ^= b;
            grp++;
            if (grp == m + 1) begin
                rb = acc; acc = 0; grp = 0; emit = 0; ebit = 0;
                if (!vn) begin
                    emit = 1; ebit = rb;
                end else if (!have) begin
                    older = rb; have = 1;
                end else begin
                    have = 0;
                    if (older != rb) begin emit = 1; ebit = older; end
                end
                if (emit) begin
                    w = {w[30:0], ebit};
                    nb++;
                    last_c = c;
                end
            end
        end
    endtask

    task automatic run(string tag, int n, int m, int d, bit vn, int sel, output logic [31:0] got);
        logic [31:0] exp_w;
        int exp_c, got_c = -1, init_c = -1, nsamp = 0, nbad = 0, ready_c = -1;
        @(negedge clk);
        enable = 0; word_read = 1;
        samp_div = 8'(n); red_div = 8'(m); warm_cnt = 8'(d); unbias_en = vn;
        @(negedge clk);
        word_read = 0;
        @(negedge clk);
        got = '0;
        for (int c = 1; c <= 8000 && got_c < 0; c++) begin
            raw_bit = pat(sel, c);
            enable = 1;
            @(posedge clk);
            @(negedge clk);
            if (samp_stb) begin
                nsamp++;
                if (samp_bit != pat(sel, c)) nbad++;
            end
            if (init_pulse && init_c < 0) init_c = c;
            if (ready_pulse && ready_c < 0) ready_c = c;
            if (result_valid) begin got_c = c; got = result; end
        end
        model(n, m, d, vn, sel, exp_w, exp_c);
        check(got == exp_w, {tag, " word content"}, got, exp_w);
        check(got_c == exp_c + 3, "R6 valid three edges after last sample", got_c, exp_c + 3);
        check(ready_c == got_c, "R6 ready pulse with valid rise", ready_c, got_c);
        check(nsamp == got_c / (n + 1), "R1 sample count", nsamp, got_c / (n + 1));
        check(nbad == 0, "R1 sampled value", nbad, 0);
        check(init_c == (d + 1) * (n + 1) + 1, "R2 init pulse edge", init_c, (d + 1) * (n + 1) + 1);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(result == 0, "R9 result after reset", result, 0);
        check(!result_valid && !ready_pulse, "R9 valid and ready after reset",
              {30'd0, result_valid, ready_pulse}, 0);
        check(!init_pulse, "R9 init after reset", init_pulse, 0);
        check(!samp_stb && !red_stb && !corr_stb, "R9 strobes after reset",
              {29'd0, samp_stb, red_stb, corr_stb}, 0);
    endtask

    task automatic t_hold_read();
        logic [31:0] w, dummy;
        run("R4 hold setup", 0, 0, 0, 0, 0, w);
        for (int k = 0; k < 10; k++) begin
            raw_bit = ~raw_bit;
            @(posedge clk);
            @(negedge clk);
        end
        check(result_valid, "R7 valid held until read", result_valid, 1);
        check(result == w, "R7 word stable while valid", result, w);
        word_read = 1;
        @(posedge clk);
        @(negedge clk);
        word_read = 0;
        check(!result_valid, "R7 read clears valid", result_valid, 0);
        check(result == w, "R7 word kept after read", result, w);
        dummy = w;
    endtask

    task automatic t_restart();
        logic [31:0] w1, w2;
        run("R8 first start", 1, 1, 3, 1, 0, w1);
        @(negedge clk);
        enable = 0;
        @(negedge clk);
        for (int c = 1; c <= 37; c++) begin
            raw_bit = pat(1, c);
            enable = 1;
            @(posedge clk);
            @(negedge clk);
        end
        run("R8 restart after partial run", 1, 1, 3, 1, 0, w2);
        check(w1 == w2, "R8 restart gives fresh-start word", w2, w1);
    endtask

    initial begin
        logic [31:0] w;
        t_reset();
        run("R2 drops warm-up ones", 0, 0, 3, 0, 1, w);
        run("R3 xor groups", 2, 3, 0, 0, 0, w);
        run("R4 bypass", 0, 2, 5, 0, 0, w);
        run("R5 debias hashed", 1, 1, 3, 1, 0, w);
        run("R5 debias pair table", 0, 0, 0, 1, 2, w);
        check(w == 32'h5555_5555, "R5 pairs 00 11 01 10 give 0101", w, 32'h5555_5555);
        t_hold_read();
        t_restart();
        summary();
        $finish;
    end

endmodule